// File: doc/BRIEF.md
# Byte-Granular DMA Realignment Datapath

This block sits between the read and write halves of a DMA engine and turns a stream of aligned source bus words into a stream of aligned destination bus words. The source and destination start addresses can each sit at any byte offset within an 8-byte bus word. The block keeps leftover source bytes in a small holding buffer, shifts them to the destination byte lanes, and marks the valid lanes with byte strobes. When the source offset is larger than the destination offset, the first write cannot be formed until two source words have arrived. When it is smaller, the transfer ends with a write that carries only leftover bytes.

A transfer starts with a one-cycle `start` pulse that supplies both addresses, a byte count and a mode. In the normal mode, writes walk upward through consecutive destination words. In the constant-destination mode, every write targets the same lanes, with a unit size of 1, 2, 4 or 8 bytes. Memory address generation and descriptor handling belong to neighbouring blocks. The block reports completion with a `done` pulse and refuses a constant-destination request whose destination offset is not a multiple of the unit size.

Top module: `byte_realign_dma`

## Requirements
- R1: After reset, `rdReady`, `wrValid`, `done` and `err` are all low.
- R2: The source is consumed as consecutive aligned words, starting with the word that contains `srcAddr`. Exactly ceil((srcAddr mod 8 + xferLen) / 8) words are accepted, and no further read is accepted after that.
- R3: In normal mode (`constDst`=0), the block makes one write for each aligned destination word from the word that holds `dstAddr` to the word that holds the last byte. Byte lane i is `wrData[8i+7:8i]` and carries the source byte whose destination address is word*8+i. Strobe bit i is set exactly when that address lies in [dstAddr, dstAddr+xferLen). Data lanes whose strobe bit is clear read zero.
- R4: When the source offset exceeds the destination offset, no write handshake occurs before the second source word has been accepted.
- R5: In constant-destination mode, `unitSize` codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes per write. Write k carries stream bytes k*unit onward, placed from lane dstAddr mod 8 upward. The final write may hold fewer bytes, and it fills the lowest lanes of its unit.
- R6: In constant-destination mode, a start whose dstAddr mod 8 is not a multiple of the unit size raises `err` for one cycle. No read or write follows, and `done` does not pulse.
- R7: A start with `xferLen` of zero pulses `done` in the following cycle, with no read, no write and no `err`.
- R8: While `wrValid` is high and `wrReady` is low, `wrValid`, `wrData` and `wrStrb` hold their values. No byte is lost or duplicated under any pattern of write or read stalls.
- R9: `done` pulses for one cycle, in the cycle right after the final write handshake. A `start` that arrives during a transfer is ignored.
- R10: `wrStrb` is never zero while `wrValid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer when idle |
| srcAddr | input | 36 | Source start byte address |
| dstAddr | input | 36 | Destination start byte address |
| xferLen | input | 16 | Transfer length in bytes |
| constDst | input | 1 | Constant-destination mode select |
| unitSize | input | 2 | Constant-destination unit size code |
| rdData | input | 64 | Source word |
| rdValid | input | 1 | Source word present |
| rdReady | output | 1 | Source word accepted this cycle when valid |
| wrData | output | 64 | Destination word, aligned to destination lanes |
| wrStrb | output | 8 | Byte strobes for `wrData` |
| wrValid | output | 1 | Destination word present |
| wrReady | input | 1 | Destination word taken |
| done | output | 1 | Transfer complete pulse |
| err | output | 1 | Rejected constant-destination request pulse |

## Verification
On every cycle, the assertions check that a stalled write holds steady, that a valid write always carries at least one strobe, and that both the completion pulse and the error pulse leave the read and write handshakes idle. Byte-exact placement, read and write counts, the extra read before the first write, the completion timing, and the rejection of misaligned constant-destination requests can only be shown by the bench's scenarios. Those scenarios compare every write against a byte-level model of the addresses.

// File: rtl/realign_pkg.sv
package realign_pkg;
  localparam int BUS_BYTES  = 8;
  localparam int BUS_W      = 8 * BUS_BYTES;
  localparam int OFF_W      = $clog2(BUS_BYTES);
  localparam int HOLD_BYTES = 2 * BUS_BYTES;
  localparam int CNT_W      = $clog2(HOLD_BYTES + 1);
  localparam int UNIT_W     = $clog2(OFF_W + 1);

  typedef struct packed {
    logic             clear;     // empty the holding buffer
    logic             push;      // append bytes of the current source word
    logic [OFF_W-1:0] pushLane;  // first valid lane of that word
    logic [CNT_W-1:0] pushCnt;   // number of bytes appended
    logic             pop;       // write handshake retires wrCnt bytes
    logic [OFF_W-1:0] wrLane;    // destination lane of the first written byte
    logic [CNT_W-1:0] wrCnt;     // bytes in the current write
  } dpCtrl_t;
endpackage

// File: rtl/realign_ctrl.sv
module realign_ctrl
  import realign_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [OFF_W-1:0]  srcOff,
  input  logic [OFF_W-1:0]  dstOff,
  input  logic [LEN_W-1:0]  xferLen,
  input  logic              constDst,
  input  logic [UNIT_W-1:0] unitSize,
  input  logic [CNT_W-1:0]  holdCnt,
  input  logic              rdValid,
  output logic              rdReady,
  output logic              wrValid,
  input  logic              wrReady,
  output logic              done,
  output logic              err,
  output dpCtrl_t           dpCtrl
);
  logic              busy;
  logic [OFF_W-1:0]  srcOffQ, dstOffQ;
  logic              constQ;
  logic [UNIT_W-1:0] unitQ;
  logic [LEN_W-1:0]  rdLeft, wrLeft;
  logic              firstRd, firstWr;
  logic              doneQ, errQ;

  logic [CNT_W-1:0]  unitBytes, rdRoom, rdCnt, wrSpan, wrCnt;
  logic [OFF_W-1:0]  rdLane, wrLane, unitMaskIn;
  logic              rdFire, wrFire, startOk, misaligned;

  // Byte counts of the current source word and current destination write
  assign unitBytes = CNT_W'(1) << unitQ;
  assign rdLane    = firstRd ? srcOffQ : '0;
  assign rdRoom    = CNT_W'(BUS_BYTES) - CNT_W'(rdLane);
  assign rdCnt     = (rdLeft < LEN_W'(rdRoom)) ? CNT_W'(rdLeft) : rdRoom;

  assign wrLane    = (constQ || firstWr) ? dstOffQ : '0;
  assign wrSpan    = constQ ? unitBytes : (CNT_W'(BUS_BYTES) - CNT_W'(wrLane));
  assign wrCnt     = (wrLeft < LEN_W'(wrSpan)) ? CNT_W'(wrLeft) : wrSpan;

  // Handshakes: reads gated only by buffer room, writes by buffered bytes
  assign rdReady   = busy && (rdLeft != '0) && (holdCnt <= CNT_W'(BUS_BYTES));
  assign wrValid   = busy && (wrLeft != '0) && (holdCnt >= wrCnt);
  assign rdFire    = rdReady && rdValid;
  assign wrFire    = wrValid && wrReady;

  assign startOk    = !busy && start;
  assign unitMaskIn = OFF_W'((1 << unitSize) - 1);
  assign misaligned = constDst && ((dstOff & unitMaskIn) != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      srcOffQ <= '0;
      dstOffQ <= '0;
      constQ  <= 1'b0;
      unitQ   <= '0;
      rdLeft  <= '0;
      wrLeft  <= '0;
      firstRd <= 1'b0;
      firstWr <= 1'b0;
      doneQ   <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      errQ  <= 1'b0;
      if (startOk) begin
        srcOffQ <= srcOff;
        dstOffQ <= dstOff;
        constQ  <= constDst;
        unitQ   <= unitSize;
        if (xferLen == '0) begin
          doneQ <= 1'b1;
        end else if (misaligned) begin
          errQ <= 1'b1;
        end else begin
          busy    <= 1'b1;
          rdLeft  <= xferLen;
          wrLeft  <= xferLen;
          firstRd <= 1'b1;
          firstWr <= 1'b1;
        end
      end else if (busy) begin
        if (rdFire) begin
          rdLeft  <= rdLeft - LEN_W'(rdCnt);
          firstRd <= 1'b0;
        end
        if (wrFire) begin
          wrLeft  <= wrLeft - LEN_W'(wrCnt);
          firstWr <= 1'b0;
          if (wrLeft == LEN_W'(wrCnt)) begin
            busy  <= 1'b0;
            doneQ <= 1'b1;
          end
        end
      end
    end
  end

  assign done = doneQ;
  assign err  = errQ;

  always_comb begin
    dpCtrl          = '0;
    dpCtrl.clear    = startOk;
    dpCtrl.push     = rdFire;
    dpCtrl.pushLane = rdLane;
    dpCtrl.pushCnt  = rdCnt;
    dpCtrl.pop      = wrFire;
    dpCtrl.wrLane   = wrLane;
    dpCtrl.wrCnt    = wrCnt;
  end
endmodule

// File: rtl/realign_datapath.sv
module realign_datapath
  import realign_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtrl_t              dpCtrl,
  input  logic [BUS_W-1:0]     rdData,
  output logic [CNT_W-1:0]     holdCnt,
  output logic [BUS_W-1:0]     wrData,
  output logic [BUS_BYTES-1:0] wrStrb
);
  localparam int HOLD_W = 8 * HOLD_BYTES;

  logic [HOLD_W-1:0] holdQ, holdD, shifted, incoming, incMask, placed;
  logic [CNT_W-1:0]  holdCntQ, holdCntD, popAmt, keepCnt;
  logic [BUS_W-1:0]  lanesShifted;

  // Retire written bytes from the bottom, then append the new source bytes
  assign popAmt   = dpCtrl.pop ? dpCtrl.wrCnt : '0;
  assign keepCnt  = holdCntQ - popAmt;
  assign shifted  = holdQ >> {popAmt, 3'b000};
  assign incoming = {{(HOLD_W - BUS_W){1'b0}}, rdData} >> {dpCtrl.pushLane, 3'b000};

  for (genvar j = 0; j < HOLD_BYTES; j++) begin : g_mask
    assign incMask[j*8 +: 8] = (CNT_W'(j) < dpCtrl.pushCnt) ? 8'hFF : 8'h00;
  end

  assign placed = (incoming & incMask) << {keepCnt, 3'b000};

  always_comb begin
    if (dpCtrl.clear) begin
      holdD    = '0;
      holdCntD = '0;
    end else if (dpCtrl.push) begin
      holdD    = shifted | placed;
      holdCntD = keepCnt + dpCtrl.pushCnt;
    end else begin
      holdD    = shifted;
      holdCntD = keepCnt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdQ    <= '0;
      holdCntQ <= '0;
    end else begin
      holdQ    <= holdD;
      holdCntQ <= holdCntD;
    end
  end

  assign holdCnt = holdCntQ;

  // Destination word: oldest bytes moved up to the starting lane
  assign lanesShifted = holdQ[BUS_W-1:0] << {dpCtrl.wrLane, 3'b000};

  for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
    logic inSpan;
    assign inSpan = (CNT_W'(i) >= CNT_W'(dpCtrl.wrLane)) &&
                    (CNT_W'(i) < (CNT_W'(dpCtrl.wrLane) + dpCtrl.wrCnt));
    assign wrStrb[i]         = inSpan;
    assign wrData[i*8 +: 8]  = inSpan ? lanesShifted[i*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/byte_realign_dma.sv
module byte_realign_dma
  import realign_pkg::*;
#(
  parameter int ADDR_W = 36,
  parameter int LEN_W  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [ADDR_W-1:0]    srcAddr,
  input  logic [ADDR_W-1:0]    dstAddr,
  input  logic [LEN_W-1:0]     xferLen,
  input  logic                 constDst,
  input  logic [UNIT_W-1:0]    unitSize,
  input  logic [BUS_W-1:0]     rdData,
  input  logic                 rdValid,
  output logic                 rdReady,
  output logic [BUS_W-1:0]     wrData,
  output logic [BUS_BYTES-1:0] wrStrb,
  output logic                 wrValid,
  input  logic                 wrReady,
  output logic                 done,
  output logic                 err
);
  dpCtrl_t          dpCtrl;
  logic [CNT_W-1:0] holdCnt;
  logic             unusedAddrBits;

  // Only the byte offsets within a word matter to the realignment
  assign unusedAddrBits = ^{srcAddr[ADDR_W-1:OFF_W], dstAddr[ADDR_W-1:OFF_W]};

  realign_ctrl #(.LEN_W(LEN_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .srcOff   (srcAddr[OFF_W-1:0]),
    .dstOff   (dstAddr[OFF_W-1:0]),
    .xferLen  (xferLen),
    .constDst (constDst),
    .unitSize (unitSize),
    .holdCnt  (holdCnt),
    .rdValid  (rdValid),
    .rdReady  (rdReady),
    .wrValid  (wrValid),
    .wrReady  (wrReady),
    .done     (done),
    .err      (err),
    .dpCtrl   (dpCtrl)
  );

  realign_datapath dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .dpCtrl  (dpCtrl),
    .rdData  (rdData),
    .holdCnt (holdCnt),
    .wrData  (wrData),
    .wrStrb  (wrStrb)
  );
endmodule

// File: rtl/byte_realign_dma_chk.sv
module byte_realign_dma_chk
  import realign_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 rdReady,
  input logic [BUS_W-1:0]     wrData,
  input logic [BUS_BYTES-1:0] wrStrb,
  input logic                 wrValid,
  input logic                 wrReady,
  input logic                 done,
  input logic                 err
);
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> (wrValid && $stable(wrData) && $stable(wrStrb)));

  p_strb_nonzero_r10: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (wrStrb != '0));

  p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (!rdReady && !wrValid && !done));

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!rdReady && !wrValid));
endmodule

bind byte_realign_dma byte_realign_dma_chk chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .rdReady (rdReady),
  .wrData  (wrData),
  .wrStrb  (wrStrb),
  .wrValid (wrValid),
  .wrReady (wrReady),
  .done    (done),
  .err     (err)
);

// File: tb/byte_realign_dma_tb_top.sv
module byte_realign_dma_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  typedef struct packed {
    logic [35:0] srcA;
    logic [35:0] dstA;
    logic [15:0] len;
    logic        cmode;
    logic [1:0]  unit;
    logic [7:0]  wrPat;
    logic [7:0]  rdPat;
    logic [7:0]  expWr;
    logic [7:0]  expRd;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{36'h0_0000_0100, 36'h0_0000_0200, 16'd16, 1'b0, 2'd0, 8'hFF,        8'hFF,        8'd2, 8'd2},
    '{36'h9_0000_0103, 36'h4_0000_0205, 16'd20, 1'b0, 2'd0, 8'b1011_0110, 8'hFF,        8'd4, 8'd3},
    '{36'h0_0000_0106, 36'h0_0000_0201, 16'd13, 1'b0, 2'd0, 8'hFF,        8'b1101_1011, 8'd2, 8'd3},
    '{36'h0_0000_0007, 36'h0_0000_0000, 16'd1,  1'b0, 2'd0, 8'hFF,        8'hFF,        8'd1, 8'd1},
    '{36'h0_0000_0002, 36'h0_0000_0004, 16'd30, 1'b0, 2'd0, 8'b0011_0001, 8'hFF,        8'd5, 8'd4},
    '{36'h0_0000_0101, 36'h0_0000_0304, 16'd10, 1'b1, 2'd2, 8'hFF,        8'hFF,        8'd3, 8'd2},
    '{36'h0_0000_0005, 36'h0_0000_0033, 16'd5,  1'b1, 2'd0, 8'b0101_0101, 8'hFF,        8'd5, 8'd2},
    '{36'h0_0000_0003, 36'h0_0000_0040, 16'd12, 1'b1, 2'd3, 8'hFF,        8'b1010_1010, 8'd2, 8'd2}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [35:0] srcAddr = '0;
  logic [35:0] dstAddr = '0;
  logic [15:0] xferLen = '0;
  logic        constDst = 1'b0;
  logic [1:0]  unitSize = '0;
  logic [63:0] rdData = '0;
  logic        rdValid = 1'b0;
  logic        rdReady;
  logic [63:0] wrData;
  logic [7:0]  wrStrb;
  logic        wrValid;
  logic        wrReady = 1'b0;
  logic        done;
  logic        err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  byte_realign_dma dut_i (
    .clk(clk), .rstN(rstN), .start(start), .srcAddr(srcAddr), .dstAddr(dstAddr),
    .xferLen(xferLen), .constDst(constDst), .unitSize(unitSize), .rdData(rdData),
    .rdValid(rdValid), .rdReady(rdReady), .wrData(wrData), .wrStrb(wrStrb),
    .wrValid(wrValid), .wrReady(wrReady), .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic logic [7:0] srcByte(input logic [35:0] a);
    return a[7:0] ^ a[15:8] ^ {a[35:32], a[35:32]} ^ 8'h5A;
  endfunction

  function automatic logic [63:0] srcWord(input logic [32:0] wa);
    logic [63:0] w;
    for (int i = 0; i < 8; i++) w[i*8 +: 8] = srcByte({wa, 3'(i)});
    return w;
  endfunction

  // Expected write k from the address rules of R3 and R5
  task automatic expWrite(input vec_t v, input int k, output logic [63:0] d, output logic [7:0] s);
    d = '0;
    s = '0;
    for (int i = 0; i < 8; i++) begin
      logic [35:0] a;
      logic [35:0] off;
      bit inr;
      if (!v.cmode) begin
        a   = {v.dstA[35:3] + 33'(k), 3'(i)};
        inr = (a >= v.dstA) && (a < v.dstA + 36'(v.len));
        off = a - v.dstA;
      end else begin
        int g, lo, idx;
        g   = 1 << v.unit;
        lo  = int'(v.dstA[2:0]);
        idx = k * g + (i - lo);
        inr = (i >= lo) && (i < lo + g) && (idx < int'(v.len));
        off = 36'(idx);
      end
      if (inr) begin
        s[i] = 1'b1;
        d[i*8 +: 8] = srcByte(v.srcA + off);
      end
    end
  endtask

  task automatic runXfer(input vec_t v, input bit extraStart, input int id,
                         output int firstWrReads, output int wrFails);
    int rdWord, nWr, cyc, lastWrCyc, doneCyc, failsAtStart;
    bit doneSeen, errSeen;
    string tag;
    tag = v.cmode ? "R5" : "R3";
    failsAtStart = errors;
    rdWord = 0; nWr = 0; cyc = 0; lastWrCyc = -10; doneCyc = -1;
    doneSeen = 0; errSeen = 0; firstWrReads = -1;
    @(negedge clk);
    srcAddr = v.srcA; dstAddr = v.dstA; xferLen = v.len;
    constDst = v.cmode; unitSize = v.unit; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!doneSeen && cyc < 400) begin
      rdValid = v.rdPat[cyc % 8];
      rdData  = srcWord(v.srcA[35:3] + 33'(rdWord));
      wrReady = v.wrPat[cyc % 8];
      if (extraStart && cyc == 2) begin
        start = 1'b1; srcAddr = 36'h5; dstAddr = 36'h0; xferLen = 16'd3; constDst = 1'b0;
      end else begin
        start = 1'b0;
      end
      #1;
      if (done) begin doneSeen = 1; doneCyc = cyc; end
      if (err) errSeen = 1;
      if (wrValid && wrReady) begin
        logic [63:0] ed;
        logic [7:0]  es;
        expWrite(v, nWr, ed, es);
        chk(wrData == ed, $sformatf("%s vec%0d write%0d data", tag, id, nWr), wrData, ed);
        chk(wrStrb == es, $sformatf("%s vec%0d write%0d strobe", tag, id, nWr), 64'(wrStrb), 64'(es));
        chk(wrStrb != 8'h00, $sformatf("R10 vec%0d write%0d nonzero strobe", id, nWr), 64'(wrStrb), 64'hFF);
        if (nWr == 0) firstWrReads = rdWord;
        nWr++;
        lastWrCyc = cyc;
      end
      if (rdValid && rdReady) rdWord++;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0; rdValid = 1'b0; wrReady = 1'b0;
    chk(nWr == int'(v.expWr), $sformatf("%s vec%0d write count", tag, id), 64'(nWr), 64'(v.expWr));
    chk(rdWord == int'(v.expRd), $sformatf("R2 vec%0d read count", id), 64'(rdWord), 64'(v.expRd));
    chk(doneSeen, $sformatf("R9 vec%0d done seen", id), 64'(doneSeen), 64'd1);
    chk(doneCyc == lastWrCyc + 1, $sformatf("R9 vec%0d done one cycle after last write", id),
        64'(doneCyc), 64'(lastWrCyc + 1));
    chk(!errSeen, $sformatf("R6 vec%0d no err on valid request", id), 64'(errSeen), 64'd0);
    #1;
    chk(!done, $sformatf("R9 vec%0d done lasts one cycle", id), 64'(done), 64'd0);
    wrFails = errors - failsAtStart;
    repeat (2) @(negedge clk);
  endtask

  task automatic rejectTest(input logic [35:0] dA, input logic [1:0] u);
    @(negedge clk);
    srcAddr = 36'h10; dstAddr = dA; xferLen = 16'd8; constDst = 1'b1; unitSize = u;
    start = 1'b1; rdValid = 1'b1; wrReady = 1'b1; rdData = srcWord(33'h2);
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(err == 1'b1, "R6 err pulse on misaligned constant destination", 64'(err), 64'd1);
    chk(done == 1'b0, "R6 no done on rejected request", 64'(done), 64'd0);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      #1;
      chk(!rdReady && !wrValid, "R6 no read or write after rejection",
          64'({rdReady, wrValid}), 64'd0);
    end
    chk(err == 1'b0, "R6 err lasts one cycle", 64'(err), 64'd0);
    rdValid = 1'b0; wrReady = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        checks++;
        errors++;
        $display("FAIL R9 watchdog: cycles %0d expected below %0d", cycles, WATCHDOG);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int fwr, wf;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk(rdReady == 1'b0, "R1 rdReady after reset", 64'(rdReady), 64'd0);
    chk(wrValid == 1'b0, "R1 wrValid after reset", 64'(wrValid), 64'd0);
    chk(done == 1'b0, "R1 done after reset", 64'(done), 64'd0);
    chk(err == 1'b0, "R1 err after reset", 64'(err), 64'd0);

    for (int n = 0; n < NVEC; n++) begin
      runXfer(VECS[n], 1'b0, n, fwr, wf);
      if (n == 2)
        chk(fwr >= 2, "R4 second source word accepted before first write", 64'(fwr), 64'd2);
      if (n == 4)
        chk(wf == 0, "R8 no byte lost under write backpressure", 64'(wf), 64'd0);
    end

    // R9: a start during a running transfer is ignored
    runXfer(VECS[1], 1'b1, 100, fwr, wf);
    chk(wf == 0, "R9 start while busy ignored", 64'(wf), 64'd0);

    // R7: zero length completes at once
    @(negedge clk);
    srcAddr = 36'h21; dstAddr = 36'h46; xferLen = 16'd0; constDst = 1'b0; unitSize = 2'd0;
    start = 1'b1; rdValid = 1'b1; wrReady = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(done == 1'b1, "R7 done pulse for zero length", 64'(done), 64'd1);
    chk(err == 1'b0, "R7 no err for zero length", 64'(err), 64'd0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      #1;
      chk(!rdReady && !wrValid, "R7 no read or write for zero length",
          64'({rdReady, wrValid}), 64'd0);
    end
    rdValid = 1'b0; wrReady = 1'b0;

    // R6: misaligned constant destination rejected
    rejectTest(36'h302, 2'd2);
    rejectTest(36'h0_0000_0044, 2'd3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule